// File: doc/BRIEF.md
# Write-Protected Asynchronous SRAM Bus Front-End

This block connects a byte-wide asynchronous memory bus (address, data, and three active-low strobes for chip select, write and output drive) to a clocked byte array. The strobes, address and write data pass through a two-stage synchronizer. Read and write cycles are decoded from the synchronized strobes. A read drives the stored byte onto the data lines. A write opens when the second of chip select and write strobe goes low, and commits when the first of the two goes high. The address and data that are current at that release are stored.

A power-good input guards the array. While it is low, no write can open or commit, a write already open is dropped, and the data drivers are released. The bidirectional data bus is split into an input byte, an output byte and an output-enable bit. The array depth is a parameter, so a reduced array can stand in for the full 512K x 8 space. An address at or above the modelled depth is treated as unbacked.

Top module: `sram_bus_frontend`

## Requirements
- R1: After reset the data drivers are off (`bus_doe`=0, `bus_dout`=0) and every modelled location reads back as 0x00.
- R2: With `pwr_ok`=1, `bus_ce_n`=0, `bus_oe_n`=0 and `bus_we_n`=1 held steady, `bus_doe` is 1 and `bus_dout` shows the byte stored at `bus_addr` within four clocks. In every other case `bus_doe` is 0 and `bus_dout` is 0x00.
- R3: A write opens when the later of `bus_ce_n` and `bus_we_n` falls. It commits `bus_din` to `bus_addr` as they stand when the earlier of the two rises. Either order of falling and of rising is accepted, and data changed after that rise is not stored.
- R4: When `bus_we_n` falls while a read is driving, `bus_doe` drops to 0 within four clocks.
- R5: While `pwr_ok`=0, `bus_doe` is 0 and `bus_dout` is 0x00, whatever the strobes are.
- R6: A write whose strobes fall while `pwr_ok`=0 is not stored. This holds even if `pwr_ok` returns before the strobes rise, because a write needs a fresh falling edge seen with power good.
- R7: A write that is open when `pwr_ok` falls is dropped and stores nothing, even after `pwr_ok` returns and the strobes rise.
- R8: An address at or above DEPTH (256 by default) is unbacked. A write there changes nothing. A read there drives `bus_doe`=1 with `bus_dout`=0x00. Lower locations are unaffected.
- R9: The level of `bus_oe_n` does not affect whether a write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply in tolerance; low forces write protection and releases the bus |
| bus_addr | input | 19 | Byte address |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Output drive request, active low |
| bus_din | input | 8 | Data from the bus |
| bus_dout | output | 8 | Data to the bus, 0x00 when not driving |
| bus_doe | output | 1 | Data driver enable |

## Verification
A falling write strobe can turn off a read that is driving and open a write in the same cycle. The bench provokes this by pulling `bus_we_n` low during a read with output drive still requested. It checks that the drivers are released, and then, after the strobe rises, checks that the new byte was stored. A power loss can also coincide with an open write. The bench drops `pwr_ok` while both strobes are low, restores it, releases the strobes, and judges by reading the location back unchanged.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;

  // strobe bundle after synchronization, all active low
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  // a read is requested: selected, drive requested, no write strobe
  function automatic logic read_request(input strobe_t s);
    return !s.ce_n && !s.oe_n && s.we_n;
  endfunction

  // both write-framing strobes active
  function automatic logic write_window(input strobe_t s);
    return !s.ce_n && !s.we_n;
  endfunction

endpackage

// File: rtl/sfe_sync.sv
`timescale 1ns/1ps
module sfe_sync #(
  parameter int              W      = 8,
  parameter logic [W-1:0]    INIT   = '0,
  parameter int              STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= INIT;
      end else if (g == 0) begin
        stage_q[g] <= d;
      end else begin
        stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sfe_cycle_ctl.sv
`timescale 1ns/1ps
module sfe_cycle_ctl
  import sfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwr_ok,
  input  strobe_t stb,
  output logic    rd_sel,
  output logic    wr_start,
  output logic    wr_commit,
  output logic    wr_abort,
  output logic    wr_live
);

  logic win_now;
  logic win_q;

  assign win_now = write_window(stb);
  assign rd_sel  = read_request(stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_now;
  end

  // open only on a fresh window edge seen with power good
  assign wr_start  = win_now && !win_q && pwr_ok;
  // close on the first strobe release
  assign wr_commit = wr_live && !win_now && pwr_ok;
  // drop on power loss
  assign wr_abort  = wr_live && !pwr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wr_live <= 1'b0;
    else if (wr_abort || wr_commit)  wr_live <= 1'b0;
    else if (wr_start)               wr_live <= 1'b1;
  end

  // R3: a commit closes the write
  p_commit_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_live);

  // R7: an abort closes the write
  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> !wr_live);

  // R6: no write survives a cycle without power
  p_unpowered_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !wr_live);

  // R3: an opened write is tracked
  p_start_sets_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> wr_live);

endmodule

// File: rtl/sfe_array.sv
`timescale 1ns/1ps
module sfe_array #(
  parameter int ADDR_W = 19,
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign hit   = ({1'b0, addr} < (ADDR_W+1)'(DEPTH));
  assign idx   = addr[IDX_W-1:0];
  assign rdata = hit ? mem_q[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en && hit) begin
      mem_q[idx] <= wdata;
    end
  end

  // R3: a committed byte is what the same address reads next cycle
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=> (!$stable(addr) || rdata == $past(wdata)));

  // R8: unbacked addresses read as zero
  p_oob_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == '0);

endmodule

// File: rtl/sram_bus_frontend.sv
`timescale 1ns/1ps
module sram_bus_frontend
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe
);

  localparam int SYNC_W = 3 + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_INIT = {3'b111, {(ADDR_W+DATA_W){1'b0}}};

  logic [SYNC_W-1:0] raw_bundle;
  logic [SYNC_W-1:0] sync_bundle;
  strobe_t           stb_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  logic rd_sel, wr_start, wr_commit, wr_abort, wr_live;
  logic hit;
  logic [DATA_W-1:0] rdata;

  assign raw_bundle = {bus_ce_n, bus_we_n, bus_oe_n, bus_addr, bus_din};
  assign {stb_s, addr_s, din_s} = sync_bundle;

  sfe_sync #(.W(SYNC_W), .INIT(SYNC_INIT), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bundle),
    .q     (sync_bundle)
  );

  sfe_cycle_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .stb       (stb_s),
    .rd_sel    (rd_sel),
    .wr_start  (wr_start),
    .wr_commit (wr_commit),
    .wr_abort  (wr_abort),
    .wr_live   (wr_live)
  );

  sfe_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_commit),
    .addr  (addr_s),
    .wdata (din_s),
    .hit   (hit),
    .rdata (rdata)
  );

  assign bus_doe  = pwr_ok && rd_sel;
  assign bus_dout = bus_doe ? rdata : '0;

  // R4: an active write strobe never coexists with driving
  p_we_blocks_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_s.we_n |-> !bus_doe);

  // R5: no drive while the supply is out of tolerance
  p_no_drive_unpowered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (!bus_doe && bus_dout == '0));

  // R2: data lines are quiet whenever not driving
  p_quiet_when_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe |-> bus_dout == '0);

endmodule

// File: tb/sram_bus_frontend_tb_top.sv
`timescale 1ns/1ps
module sram_bus_frontend_tb_top;

  localparam int TB_DEPTH = 256;
  localparam int NVEC     = 9;
  localparam int VW       = 2 + 19 + 8;
  // kind: 0 = write, write strobe falls first; 1 = write, chip select falls first; 2 = read and compare
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {2'd0, 19'd5,   8'h5A},
    {2'd1, 19'd16,  8'hC3},
    {2'd0, 19'd255, 8'h81},
    {2'd2, 19'd5,   8'h5A},
    {2'd2, 19'd16,  8'hC3},
    {2'd2, 19'd255, 8'h81},
    {2'd1, 19'd5,   8'h12},
    {2'd2, 19'd5,   8'h12},
    {2'd2, 19'd6,   8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_ok = 1'b1;
  logic [18:0] bus_addr = '0;
  logic        bus_ce_n = 1'b1;
  logic        bus_we_n = 1'b1;
  logic        bus_oe_n = 1'b1;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout;
  logic        bus_doe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_bus_frontend #(.ADDR_W(19), .DATA_W(8), .DEPTH(TB_DEPTH)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .bus_addr (bus_addr),
    .bus_ce_n (bus_ce_n),
    .bus_we_n (bus_we_n),
    .bus_oe_n (bus_oe_n),
    .bus_din  (bus_din),
    .bus_dout (bus_dout),
    .bus_doe  (bus_doe)
  );

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual doe/dout=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_idle();
    bus_ce_n = 1'b1; bus_we_n = 1'b1; bus_oe_n = 1'b1;
  endtask

  // write strobe falls first, chip select opens and closes the write
  task automatic wr_we_first(input logic [18:0] a, input logic [7:0] d);
    bus_addr = a; bus_din = d; settle();
    bus_we_n = 1'b0; settle();
    bus_ce_n = 1'b0; settle();
    bus_ce_n = 1'b1; settle();
    bus_din = ~d; settle();
    bus_we_n = 1'b1; settle();
  endtask

  // chip select falls first, write strobe opens and closes the write
  task automatic wr_ce_first(input logic [18:0] a, input logic [7:0] d);
    bus_addr = a; bus_din = d; settle();
    bus_ce_n = 1'b0; settle();
    bus_we_n = 1'b0; settle();
    bus_we_n = 1'b1; settle();
    bus_din = ~d; settle();
    bus_ce_n = 1'b1; settle();
  endtask

  task automatic rd_chk(input string tag, input logic [18:0] a, input logic [7:0] exp);
    bus_addr = a; bus_ce_n = 1'b0; bus_oe_n = 1'b0; settle();
    chk(tag, {bus_doe, bus_dout}, {1'b1, exp});
    bus_idle(); settle();
    chk(tag, {bus_doe, bus_dout}, 9'h000);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 drivers off in reset", {bus_doe, bus_dout}, 9'h000);
    rst_n = 1'b1; settle();
    chk("R1 drivers off after reset", {bus_doe, bus_dout}, 9'h000);
    rd_chk("R1 location reads zero", 19'd3, 8'h00);

    // table walk: R3 writes in both strobe orders, R2 reads
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  k;
      logic [18:0] a;
      logic [7:0]  d;
      {k, a, d} = VEC[i];
      case (k)
        2'd0:    wr_we_first(a, d);
        2'd1:    wr_ce_first(a, d);
        default: rd_chk("R2/R3 table read", a, d);
      endcase
    end

    // R2: output request missing -> no drive
    bus_addr = 19'd5; bus_ce_n = 1'b0; settle();
    chk("R2 no drive without output request", {bus_doe, bus_dout}, 9'h000);
    bus_idle(); settle();

    // R4 + R9: write strobe falls during an active read, output request stays low
    bus_addr = 19'd5; bus_din = 8'h77; bus_ce_n = 1'b0; bus_oe_n = 1'b0; settle();
    chk("R4 read driving before strobe", {bus_doe, bus_dout}, {1'b1, 8'h12});
    bus_we_n = 1'b0; settle();
    chk("R4 drivers released on write strobe", {bus_doe, bus_dout}, 9'h000);
    bus_we_n = 1'b1; settle();
    bus_din = 8'h00; bus_idle(); settle();
    rd_chk("R9 write with output request low commits", 19'd5, 8'h77);

    // R5: unpowered read attempt
    pwr_ok = 1'b0;
    bus_addr = 19'd5; bus_ce_n = 1'b0; bus_oe_n = 1'b0; settle();
    chk("R5 no drive while unpowered", {bus_doe, bus_dout}, 9'h000);
    bus_idle(); settle();

    // R6: whole write while unpowered
    wr_we_first(19'd20, 8'hAA);
    pwr_ok = 1'b1; settle();
    rd_chk("R6 unpowered write not stored", 19'd20, 8'h00);

    // R6: strobes fall unpowered, power returns before release
    pwr_ok = 1'b0;
    bus_addr = 19'd20; bus_din = 8'hBB; settle();
    bus_ce_n = 1'b0; bus_we_n = 1'b0; settle();
    pwr_ok = 1'b1; settle();
    bus_idle(); settle();
    rd_chk("R6 no fresh edge no store", 19'd20, 8'h00);

    // R7: open write aborted by power loss
    bus_addr = 19'd21; bus_din = 8'h55; settle();
    bus_ce_n = 1'b0; bus_we_n = 1'b0; settle();
    pwr_ok = 1'b0; settle();
    pwr_ok = 1'b1; settle();
    bus_idle(); settle();
    rd_chk("R7 aborted write not stored", 19'd21, 8'h00);

    // R8: unbacked address
    wr_ce_first(19'd300, 8'h99);
    rd_chk("R8 unbacked read zero", 19'd300, 8'h00);
    rd_chk("R8 alias location untouched", 19'd44, 8'h00);
    rd_chk("R8 backed location intact", 19'd255, 8'h81);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule